// File: doc/BRIEF.md
# Triple-Redundant Request/Acknowledge Sequencer

This block is a small control sequencer built as three identical copies. The copies vote on their state. It walks through four phases: idle, issuing a request, waiting for an acknowledge, and signalling completion. A start pulse in idle launches the request phase. An acknowledge ends the wait phase. An external timeout pulse abandons the wait and returns the sequencer to idle.

Each copy computes its own next state and its own outputs. A bitwise majority vote over the three next-state values is fed back into all three state registers, so a copy whose register was upset comes back into line at the next clock. A second vote drives the request and done outputs. A third vote over the current states gives the reference for a mismatch flag, which rises whenever any copy disagrees with the majority. The voters hold no registers. A test-only injection port can invert one chosen bit of one chosen copy's state register as it loads, which lets the correction be exercised in simulation.

Top module: `tmr_seq_fsm`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, req_o, done_o and mismatch_o are 0. All three copies are held in idle.
- R2: When start_i is high at a clock edge while idle, req_o is high for exactly the following cycle. With start_i low in idle, the sequencer stays idle.
- R3: The request phase always moves to the wait phase at the next edge, whatever the inputs. In the wait phase req_o and done_o are 0, start_i has no effect, and the phase holds until ack_i or timeout_i is seen.
- R4: When ack_i is high at an edge in the wait phase, done_o is high for exactly the next cycle, and the sequencer then returns to idle.
- R5: When timeout_i is high and ack_i is low at an edge in the wait phase, the sequencer returns to idle without raising done_o. If both are high, ack_i wins.
- R6: req_o and done_o are never high together.
- R7: A single-bit inversion injected into any copy at any edge leaves req_o and done_o identical to those of a fault-free run. inj_copy_i values 0, 1 and 2 select a copy, and inj_bit_i selects a bit of its 2-bit state.
- R8: mismatch_o is high in the cycle after an edge that injected into copy 0, 1 or 2. After an edge with no injection it is 0, because the faulty copy reloads from the voted next state.
- R9: An injection with inj_copy_i equal to 3 selects no copy and has no effect: mismatch_o stays 0 and the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a request cycle from idle |
| ack_i | input | 1 | Acknowledge that ends the wait phase |
| timeout_i | input | 1 | Pulse that abandons the wait phase |
| inj_en_i | input | 1 | Test only: invert one state bit this edge |
| inj_copy_i | input | 2 | Test only: copy to corrupt (0 to 2; 3 selects none) |
| inj_bit_i | input | 1 | Test only: state bit to invert |
| req_o | output | 1 | Voted request output |
| done_o | output | 1 | Voted completion output |
| mismatch_o | output | 1 | Some copy's state differs from the voted state |

## Verification
All outputs are decoded combinationally from the state registers. A change in req_o or done_o caused by an input sampled at an edge therefore shows in the cycle right after that edge. The mismatch flag follows the same rule: it reflects the injection made at the previous edge and is due low one edge later. The bench applies inputs on the falling edge, advances a reference model at the rising edge, and compares every output at the next falling edge. Asynchronous reset is checked a short delay after rst_ni falls.

// File: rtl/tmr_seq_pkg.sv
package tmr_seq_pkg;
  localparam int unsigned STATE_W    = 2;
  localparam int unsigned NUM_COPIES = 3;
  localparam int unsigned OUT_W      = 2;
  localparam int unsigned COPY_SEL_W = 2;
  localparam int unsigned BIT_SEL_W  = (STATE_W > 1) ? $clog2(STATE_W) : 1;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter #(
  parameter int unsigned W = 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  // purely combinational: no flop shared by all copies
  assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/tmr_seq_copy.sv
module tmr_seq_copy
  import tmr_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               ack_i,
  input  logic               timeout_i,
  input  logic [STATE_W-1:0] voted_nxt_i,
  input  logic [STATE_W-1:0] flip_i,
  output logic [STATE_W-1:0] state_o,
  output logic [STATE_W-1:0] nxt_o,
  output logic               req_o,
  output logic               done_o
);
  logic [STATE_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= voted_nxt_i ^ flip_i;
  end

  always_comb begin
    nxt_o = state_q;
    case (state_q)
      ST_IDLE: if (start_i) nxt_o = ST_REQ;
      ST_REQ:  nxt_o = ST_WAIT;
      ST_WAIT: begin
        if (ack_i)          nxt_o = ST_DONE;
        else if (timeout_i) nxt_o = ST_IDLE;
      end
      default: nxt_o = ST_IDLE;
    endcase
  end

  assign state_o = state_q;
  assign req_o   = (state_q == ST_REQ);
  assign done_o  = (state_q == ST_DONE);

  p_copy_follows_vote_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_i == '0) |=> (state_q == $past(voted_nxt_i)));
endmodule

// File: rtl/tmr_seq_fsm.sv
module tmr_seq_fsm
  import tmr_seq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  ack_i,
  input  logic                  timeout_i,
  input  logic                  inj_en_i,
  input  logic [COPY_SEL_W-1:0] inj_copy_i,
  input  logic [BIT_SEL_W-1:0]  inj_bit_i,
  output logic                  req_o,
  output logic                  done_o,
  output logic                  mismatch_o
);
  logic [STATE_W-1:0] st   [NUM_COPIES];
  logic [STATE_W-1:0] nx   [NUM_COPIES];
  logic [STATE_W-1:0] flip [NUM_COPIES];
  logic [OUT_W-1:0]   outs [NUM_COPIES];
  logic [STATE_W-1:0] voted_nxt;
  logic [STATE_W-1:0] voted_st;
  logic [OUT_W-1:0]   voted_out;

  for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
    logic c_req, c_done;
    assign flip[g] = (inj_en_i && inj_copy_i == COPY_SEL_W'(g))
                   ? (STATE_W'(1) << inj_bit_i) : '0;
    tmr_seq_copy u_copy (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .ack_i       (ack_i),
      .timeout_i   (timeout_i),
      .voted_nxt_i (voted_nxt),
      .flip_i      (flip[g]),
      .state_o     (st[g]),
      .nxt_o       (nx[g]),
      .req_o       (c_req),
      .done_o      (c_done)
    );
    assign outs[g] = {c_req, c_done};
  end

  tmr_maj_voter #(.W(STATE_W)) u_vote_nxt (
    .a_i(nx[0]), .b_i(nx[1]), .c_i(nx[2]), .y_o(voted_nxt));
  tmr_maj_voter #(.W(STATE_W)) u_vote_st (
    .a_i(st[0]), .b_i(st[1]), .c_i(st[2]), .y_o(voted_st));
  tmr_maj_voter #(.W(OUT_W)) u_vote_out (
    .a_i(outs[0]), .b_i(outs[1]), .c_i(outs[2]), .y_o(voted_out));

  assign req_o  = voted_out[1];
  assign done_o = voted_out[0];

  always_comb begin
    mismatch_o = 1'b0;
    for (int i = 0; i < NUM_COPIES; i++)
      if (st[i] != voted_st) mismatch_o = 1'b1;
  end

  p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  p_req_from_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(start_i));
  p_wait_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (voted_st == ST_WAIT && !ack_i && !timeout_i) |=> (voted_st == ST_WAIT));
  p_ack_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (voted_st == ST_WAIT && ack_i) |=> done_o);
  p_timeout_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (voted_st == ST_WAIT && timeout_i && !ack_i) |=> (voted_st == ST_IDLE && !done_o));
  p_outs_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && done_o));
  p_clean_after_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_en_i |=> !mismatch_o);
  p_no_copy_three_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_en_i && inj_copy_i == COPY_SEL_W'(3)) |=> !mismatch_o);
endmodule

// File: tb/tmr_seq_fsm_test.sv
`timescale 1ns/1ps
module tmr_seq_fsm_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, ack_i = 1'b0, timeout_i = 1'b0;
  logic       inj_en_i = 1'b0;
  logic [1:0] inj_copy_i = 2'd0;
  logic [0:0] inj_bit_i = 1'b0;
  logic       req_o, done_o, mismatch_o;

  int checks = 0;
  int errors = 0;
  int exp_st = 0;       // 0 idle, 1 request, 2 wait, 3 done
  logic exp_mis = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk_i = ~clk_i;

  tmr_seq_fsm uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ack_i(ack_i),
    .timeout_i(timeout_i), .inj_en_i(inj_en_i), .inj_copy_i(inj_copy_i),
    .inj_bit_i(inj_bit_i), .req_o(req_o), .done_o(done_o), .mismatch_o(mismatch_o)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag, string mtag);
    chk(tag, "req_o", req_o, exp_st == 1);
    chk(tag, "done_o", done_o, exp_st == 3);
    chk((exp_st == 1 || exp_st == 3) ? tag : "R6", "req_o&done_o", req_o & done_o, 1'b0);
    chk(mtag, "mismatch_o", mismatch_o, exp_mis);
  endtask

  function automatic int model_next(int st, logic s, logic a, logic t);
    case (st)
      0: return s ? 1 : 0;
      1: return 2;
      2: return a ? 3 : (t ? 0 : 2);
      default: return 0;
    endcase
  endfunction

  task automatic cyc(logic s, logic a, logic t, logic ie, logic [1:0] ic,
                     logic ib, string tag);
    string mtag;
    start_i = s; ack_i = a; timeout_i = t;
    inj_en_i = ie; inj_copy_i = ic; inj_bit_i = ib;
    @(posedge clk_i);
    exp_st  = model_next(exp_st, s, a, t);
    exp_mis = ie && (ic != 2'd3);
    mtag = (ie && ic == 2'd3) ? "R9" : "R8";
    @(negedge clk_i);
    check_all(tag, mtag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check_all("R1", "R1");
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 1, 1, 0, 0, 0, "R2");       // idle holds without start
    cyc(1, 0, 0, 0, 0, 0, "R2");       // request
    cyc(1, 1, 1, 0, 0, 0, "R3");       // request always moves to wait
    cyc(1, 0, 0, 0, 0, 0, "R3");       // start ignored in wait
    cyc(0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 1, 1, 0, 0, 0, "R5");       // ack wins over timeout
    cyc(1, 0, 0, 0, 0, 0, "R4");       // done lasts one cycle, back to idle
    cyc(1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, "R5");       // timeout to idle, no done
    cyc(0, 0, 0, 0, 0, 0, "R5");
    // R7/R8/R9: inject every copy/bit in every state
    for (int st = 0; st < 4; st++) begin
      for (int c = 0; c < 4; c++) begin
        for (int b = 0; b < 2; b++) begin
          while (exp_st != st) cyc(exp_st == 0, 1'b1, 1'b0, 0, 0, 0, "R4");
          cyc(exp_st == 0, 1'b1, 1'b0, 1'b1, 2'(c), 1'(b), c == 3 ? "R9" : "R7");
          cyc(exp_st == 0, 1'b1, 1'b0, 1'b0, 0, 0, "R7");
        end
      end
    end
    // pseudo-random sweep mixing stimulus and injections
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[1] & lf[2], lf[3], lf[4] & lf[5], lf[7:6], lf[8],
          (lf[4] & lf[5]) ? "R7" : "R3");
    end
    // R1: asynchronous reset in mid-sequence
    while (exp_st != 1) cyc(1'b1, 1'b0, 1'b0, 0, 0, 0, "R2");
    #2 rst_ni = 1'b0;
    #1;
    exp_st = 0; exp_mis = 1'b0;
    check_all("R1", "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule